// File: doc/BRIEF.md
# Edge and Gated-Time Pulse Accumulator

This block counts pulses on a primary input. Its two 8-bit counter slices can be chained into one 16-bit accumulator, or they can be split. In split mode the lower slice follows the primary input and the upper slice counts edges on a second input. The block supports two ways of counting. In event counting, every active edge of the primary input adds one. In gated time accumulation, every cycle that carries a prescaled tick adds one while the primary input holds its active gate level. Both inputs pass through a two-flop synchroniser before edge detection. A control bit selects the active polarity.

A two-bit status register records counter overflow and input activity. The overflow flag has three sources: a wrap of the chained 16-bit value, a wrap of the upper slice in split mode, and an active edge that reaches the upper slice while it is held at its maximum in saturating mode. In event mode the input flag records each active edge. In gated mode it records the trailing edge of the gate. Software normally clears a flag by writing one to it. A fast-clear option instead clears both flags on any read of a count byte. Each flag drives its own interrupt request line through an enable bit. A small four-register bus gives access to the control, status and count bytes.

Top module: `pacc_unit`

## Requirements
- R1: After reset, the control, status, upper-count and lower-count registers all read zero, and both interrupt outputs are low.
- R2: The status register is at address 1, with overflow at bit 1 and input flag at bit 0. Bits 7 to 2 read as zero and ignore writes. Address 0 is control: bit0 enable, bit1 gated mode, bit2 falling polarity, bit3 split, bit4 saturate, bit5 fast clear, bit6 overflow interrupt enable, bit7 input interrupt enable. Address 2 is the upper count byte and address 3 is the lower count byte, and both can be written.
- R3: When fast clear is off, writing one to a status bit clears it and writing zero leaves it unchanged. Reads never alter the status.
- R4: When fast clear is on, writes to the status register have no effect. A read of address 2 or 3 clears both flags.
- R5: In chained event mode, each active edge of the primary input (rising when bit2 is 0, falling when bit2 is 1) increments the 16-bit count.
- R6: A chained count that wraps from 0xFFFF to 0x0000 sets the overflow flag.
- R7: In split mode, the lower byte counts primary edges and wraps at 0xFF without setting a flag. The upper byte counts active edges of the second input, and its wrap from 0xFF to 0x00 sets the overflow flag.
- R8: In split mode with saturate set, an active second-input edge that arrives while the upper byte holds 0xFF keeps it at 0xFF and sets the overflow flag.
- R9: In gated mode, the count increments on every tick cycle while the gate is at its active level (high for bit2 = 0). The trailing edge of the gate sets the input flag, and the leading edge does not.
- R10: In event mode, each active primary edge sets the input flag.
- R11: Each interrupt output equals its flag ANDed with its enable bit.
- R12: When a flag is set by hardware and cleared by software in the same cycle, the flag ends set.
- R13: With the enable bit at 0, input edges and ticks neither change the count nor set flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| evt_in | input | 1 | Primary event or gate input (asynchronous) |
| aux_in | input | 1 | Second event input for the upper slice in split mode (asynchronous) |
| tick_in | input | 1 | Prescaled one-cycle tick used in gated mode |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-flag interrupt request |

## Verification
The assertions check every cycle that a hardware set always lands in the flag, even when a clear happens in the same cycle. They also check that fast-clear mode holds the flags against writes, that the chained count returns to zero after it wraps, that a saturated upper slice stays at its maximum, and that an edge pulse never lasts two cycles. Other behaviours can only be seen through the bench's scenarios. These include the selected polarity, the leading versus trailing edge in gated mode, the read-triggered clear, the effect of the enable bit, and the random edge streams compared against the bench's own count model.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_FLAG = 2'd1,
    A_CHI  = 2'd2,
    A_CLO  = 2'd3
  } pacc_addr_e;

  typedef struct packed {
    logic edge_ie;
    logic ovf_ie;
    logic fast;
    logic sat;
    logic split;
    logic pol;
    logic gated;
    logic en;
  } pacc_ctrl_t;

  localparam int FLG_EDGE = 0;
  localparam int FLG_OVF  = 1;

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  // R5
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/pacc_count.sv
module pacc_count #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          split,
  input  logic          sat,
  input  logic          lo_step,
  input  logic          hi_step,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] hi_q,
  output logic [BW-1:0] lo_q,
  output logic          wrap_evt
);
  localparam int CW = 2 * BW;
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};

  function automatic logic [CW:0] chain_inc(logic [BW-1:0] h, logic [BW-1:0] l);
    return {1'b0, h, l} + 1'b1;
  endfunction

  function automatic logic [BW:0] upper_inc(logic [BW-1:0] h, logic s);
    if (s && h == BMAX) return {1'b1, h};
    return {1'b0, h} + 1'b1;
  endfunction

  logic [CW:0]   chain;
  logic [BW:0]   up;
  logic [BW-1:0] hi_d, lo_d;
  logic          wrap_raw;

  always_comb begin
    chain    = chain_inc(hi_q, lo_q);
    up       = upper_inc(hi_q, sat);
    hi_d     = hi_q;
    lo_d     = lo_q;
    wrap_raw = 1'b0;
    if (!split) begin
      if (lo_step) begin
        {hi_d, lo_d} = chain[CW-1:0];
        wrap_raw     = chain[CW];
      end
    end else begin
      if (lo_step) lo_d = lo_q + 1'b1;
      if (hi_step) begin
        hi_d     = up[BW-1:0];
        wrap_raw = up[BW];
      end
    end
    if (wr_hi) hi_d = wdata;
    if (wr_lo) lo_d = wdata;
  end

  assign wrap_evt = wrap_raw & ~wr_hi & (split | ~wr_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R6
  chain_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && lo_step && hi_q == BMAX && lo_q == BMAX && !wr_hi && !wr_lo)
      |=> (hi_q == '0 && lo_q == '0));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split && sat && hi_step && hi_q == BMAX && !wr_hi) |=> (hi_q == BMAX));

endmodule

// File: rtl/pacc_flags.sv
module pacc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set,
  input  logic       wr_flag,
  input  logic [1:0] wbits,
  input  logic       fast,
  input  logic       rd_cnt,
  output logic [1:0] flg
);
  logic [1:0] clr;

  always_comb begin
    if (fast) clr = {2{rd_cnt}};
    else      clr = wr_flag ? wbits : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= 2'b00;
    else        flg <= (flg & ~clr) | set;
  end

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set != 2'b00) |=> ((flg & $past(set)) == $past(set)));

  // R4
  fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && !rd_cnt) |=> ((flg & $past(flg)) == $past(flg)));

endmodule

// File: rtl/pacc_unit.sv
module pacc_unit
  import pacc_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          evt_in,
  input  logic          aux_in,
  input  logic          tick_in,
  output logic          irq_ovf,
  output logic          irq_edge
);
  pacc_ctrl_t    ctrl_q;
  logic [1:0]    lvl, rise, fall;
  logic          ev_act, aux_act, gate_on, gate_trail;
  logic          lo_step, hi_step, edge_set, wrap_evt;
  logic          wr_ctrl, wr_flag, wr_hi, wr_lo, rd_cnt;
  logic [BW-1:0] hi_q, lo_q;
  logic [1:0]    flg;

  assign wr_ctrl = bus_sel & bus_wr & (bus_addr == A_CTRL);
  assign wr_flag = bus_sel & bus_wr & (bus_addr == A_FLAG);
  assign wr_hi   = bus_sel & bus_wr & (bus_addr == A_CHI);
  assign wr_lo   = bus_sel & bus_wr & (bus_addr == A_CLO);
  assign rd_cnt  = bus_sel & ~bus_wr & ((bus_addr == A_CHI) | (bus_addr == A_CLO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= pacc_ctrl_t'(bus_wdata[7:0]);
  end

  pacc_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({aux_in, evt_in}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign ev_act     = ctrl_q.pol ? fall[0] : rise[0];
  assign aux_act    = ctrl_q.pol ? fall[1] : rise[1];
  assign gate_on    = lvl[0] ^ ctrl_q.pol;
  assign gate_trail = ctrl_q.pol ? rise[0] : fall[0];

  assign lo_step  = ctrl_q.en & (ctrl_q.gated ? (tick_in & gate_on) : ev_act);
  assign hi_step  = ctrl_q.en & ctrl_q.split & aux_act;
  assign edge_set = ctrl_q.en & (ctrl_q.gated ? gate_trail : ev_act);

  pacc_count #(.BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .split(ctrl_q.split), .sat(ctrl_q.sat),
    .lo_step(lo_step), .hi_step(hi_step), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wdata(bus_wdata), .hi_q(hi_q), .lo_q(lo_q), .wrap_evt(wrap_evt)
  );

  pacc_flags u_flg (
    .clk(clk), .rst_n(rst_n), .set({wrap_evt, edge_set}),
    .wr_flag(wr_flag), .wbits(bus_wdata[1:0]), .fast(ctrl_q.fast),
    .rd_cnt(rd_cnt), .flg(flg)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = BW'(ctrl_q);
      A_FLAG:  bus_rdata = {{(BW-2){1'b0}}, flg};
      A_CHI:   bus_rdata = hi_q;
      default: bus_rdata = lo_q;
    endcase
  end

  assign irq_ovf  = flg[FLG_OVF]  & ctrl_q.ovf_ie;
  assign irq_edge = flg[FLG_EDGE] & ctrl_q.edge_ie;

endmodule

// File: tb/sim_pacc_unit.sv
`timescale 1ns/1ps
module sim_pacc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       evt_in = 1'b0, aux_in = 1'b0, tick_in = 1'b0;
  logic       irq_ovf, irq_edge;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pacc_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .aux_in(aux_in), .tick_in(tick_in),
    .irq_ovf(irq_ovf), .irq_edge(irq_edge)
  );

  function automatic logic [16:0] m_chain(logic [15:0] c);
    return {1'b0, c} + 17'd1;
  endfunction

  function automatic logic [8:0] m_upper(logic [7:0] h, bit s);
    if (s && h == 8'hFF) return {1'b1, h};
    return {1'b0, h} + 9'd1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_evt(bit v);
    @(negedge clk); evt_in = v;
  endtask

  task automatic set_aux(bit v);
    @(negedge clk); aux_in = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, h, l;
    logic [15:0] exp16;
    logic [7:0] eh, el;
    bit eovf, pv, pa;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 irq_ovf", irq_ovf, 0);
    chk("R1 irq_edge", irq_edge, 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg", d, 0);
    end

    // R5 rising edges, chained
    wr(0, 8'h01);
    for (int i = 0; i < 3; i++) begin
      set_evt(1); settle(2); set_evt(0); settle(2);
    end
    settle(3);
    rd(3, d); chk("R5 lo after 3 rises", d, 3);
    rd(2, d); chk("R5 hi", d, 0);
    // R10 edge flag
    rd(1, d); chk("R10 edge flag", d, 8'h01);
    // R2 upper bits read 0 and ignore writes; write zero no effect (R3)
    wr(1, 8'hFC);
    rd(1, d); chk("R2 R3 flag after zero-write", d, 8'h01);
    // R3 write one clears
    wr(1, 8'h01);
    rd(1, d); chk("R3 cleared", d, 0);

    // R6 chained wrap
    wr(2, 8'hFF); wr(3, 8'hFF);
    set_evt(1); settle(4); set_evt(0); settle(3);
    rd(2, h); rd(3, l);
    chk("R6 wrap count", {h, l}, 0);
    rd(1, d); chk("R6 ovf flag", d[1], 1);
    // R11 irq
    chk("R11 irq off", irq_ovf, 0);
    wr(0, 8'hC1);
    #1 chk("R11 irq_ovf", irq_ovf, 1);
    chk("R11 irq_edge", irq_edge, 1);
    wr(1, 8'h03);
    #1 chk("R11 irq cleared", irq_ovf | irq_edge, 0);

    // R5 falling polarity
    wr(0, 8'h05); wr(3, 0); wr(2, 0);
    set_evt(1); settle(4);
    rd(3, d); chk("R5 rise ignored with falling pol", d, 0);
    set_evt(0); settle(4);
    rd(3, d); chk("R5 falling counted", d, 1);
    wr(1, 8'h03);

    // R12 set wins over same-cycle clear
    wr(0, 8'h01);
    @(negedge clk); evt_in = 1;
    @(negedge clk);
    wr(1, 8'h03);
    rd(1, d); chk("R12 set wins", d[0], 1);
    set_evt(0); settle(3); wr(1, 8'h03);

    // R4 fast clear
    wr(0, 8'h21);
    set_evt(1); settle(4);
    wr(1, 8'h03);
    rd(1, d); chk("R4 write ignored in fast mode", d, 1);
    rd(3, d);
    rd(1, d); chk("R4 read clears", d, 0);
    set_evt(0); settle(3);

    // R13 disabled
    wr(0, 8'h00); wr(3, 8'h10); wr(2, 0);
    set_evt(1); settle(2); set_evt(0); settle(4);
    rd(3, d); chk("R13 no count", d, 8'h10);
    rd(1, d); chk("R13 no flag", d, 0);

    // R9 gated mode
    wr(0, 8'h03); wr(3, 0); wr(2, 0);
    set_evt(1); settle(4);
    rd(1, d); chk("R9 leading edge no flag", d, 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); tick_in = 1;
      @(negedge clk); tick_in = 0;
    end
    set_evt(0); settle(4);
    @(negedge clk); tick_in = 1; @(negedge clk); tick_in = 0;
    rd(3, d); chk("R9 gated count", d, 7);
    rd(1, d); chk("R9 trailing flag", d, 1);
    wr(1, 8'h03);

    // R8 saturate
    wr(0, 8'h19); wr(2, 8'hFF);
    set_aux(1); settle(4); set_aux(0); settle(3);
    rd(2, d); chk("R8 held at max", d, 8'hFF);
    rd(1, d); chk("R8 ovf", d[1], 1);
    wr(1, 8'h03);
    // R7 non-saturating upper wrap
    wr(0, 8'h09);
    set_aux(1); settle(4); set_aux(0); settle(3);
    rd(2, d); chk("R7 upper wrap", d, 0);
    rd(1, d); chk("R7 ovf", d[1], 1);
    wr(1, 8'h03);
    // R7 lower wrap no flag
    wr(3, 8'hFF);
    set_evt(1); settle(4); set_evt(0); settle(3);
    rd(3, d); chk("R7 lower wrap", d, 0);
    rd(1, d); chk("R7 lower wrap no ovf", d[1], 0);
    wr(1, 8'h03);

    // R5 random chained stream
    wr(0, 8'h01); wr(2, 8'hFF); wr(3, 8'hF0);
    exp16 = 16'hFFF0; eovf = 0; pv = 0;
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = $urandom % 2;
      @(negedge clk); evt_in = v;
      if (v && !pv) begin
        eovf |= m_chain(exp16)[16];
        exp16 = m_chain(exp16)[15:0];
      end
      pv = v;
    end
    @(negedge clk); evt_in = 0; settle(4);
    rd(2, h); rd(3, l);
    chk("R5 random chained count", {h, l}, exp16);
    rd(1, d); chk("R6 random ovf", d[1], eovf);
    wr(1, 8'h03);

    // R7 random split stream
    wr(0, 8'h09); wr(2, 8'hF8); wr(3, 8'h00);
    eh = 8'hF8; el = 0; eovf = 0; pv = 0; pa = 0;
    for (int i = 0; i < 300; i++) begin
      bit v, a;
      v = $urandom % 2; a = $urandom % 2;
      @(negedge clk); evt_in = v; aux_in = a;
      if (v && !pv) el = el + 1;
      if (a && !pa) begin
        eovf |= m_upper(eh, 0)[8];
        eh = m_upper(eh, 0)[7:0];
      end
      pv = v; pa = a;
    end
    @(negedge clk); evt_in = 0; aux_in = 0; settle(4);
    rd(2, h); rd(3, l);
    chk("R7 random upper", h, eh);
    chk("R7 random lower", l, el);
    rd(1, d); chk("R7 random ovf", d[1], eovf);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule